// File: doc/BRIEF.md
# Bidirectional-Port Universal Shift Register

This block is a parameterised register (eight bits by default) with four clocked modes chosen by a two-bit mode input. It can keep its contents, shift toward the high bit, shift toward the low bit, or capture a word in parallel. The parallel word arrives and leaves on a single set of shared bidirectional lines. A resolved inout models those lines, and the block also exposes the driver's data and its enable as a separate output pair.

The register puts its contents on the shared lines only when both active-low output enables are low and the block is not in parallel-load mode. At all other times the lines float, and an external agent can drive them. Two serial outputs always show the lowest and the highest bit, whatever the enables do. Registers can therefore be chained through the serial inputs to form longer shift paths. An active-low reset clears the register asynchronously.

Top module: `bidir_shift_reg`

## Requirements
- R1: With mode 2'b11 (parallel load), a rising clock edge copies ioBus bit n into register bit n.
- R2: While rstN is low, every register bit is 0 at once, with no clock edge needed and whatever the mode.
- R3: The first rising edge after rstN goes high acts on the mode inputs with no added latency.
- R4: With mode 2'b01, a rising edge moves each bit n to bit n+1 and loads serInLow into bit 0.
- R5: With mode 2'b10, a rising edge moves each bit n to bit n-1 and loads serInHigh into the top bit.
- R6: With mode 2'b00, a rising edge leaves the register unchanged.
- R7: When oeAN and oeBN are both low and the mode is not 2'b11, dataOutEn is 1 and ioBus carries the register contents.
- R8: When oeAN or oeBN is high, dataOutEn is 0 and the block does not drive ioBus.
- R9: In mode 2'b11, dataOutEn is 0 whatever the state of the enables.
- R10: serOutLow always equals register bit 0 and serOutHigh always equals the top bit, whatever the state of the enables.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Rising-edge clock |
| rstN | input | 1 | Asynchronous reset, active low |
| modeSel | input | 2 | 00 hold, 01 shift up, 10 shift down, 11 load |
| serInLow | input | 1 | Serial bit entering bit 0 on shift up |
| serInHigh | input | 1 | Serial bit entering the top bit on shift down |
| oeAN | input | 1 | Output enable A, active low |
| oeBN | input | 1 | Output enable B, active low |
| ioBus | inout | WIDTH | Shared parallel data lines |
| dataOut | output | WIDTH | Register contents, i.e. the driver data |
| dataOutEn | output | 1 | Driver enable for ioBus |
| serOutLow | output | 1 | Register bit 0 |
| serOutHigh | output | 1 | Register top bit |

## Verification
The bench builds the block at the default width of eight bits. At that width, hand-computed vectors for shift and load can show bits entering at both ends and leaving at the far end within a few edges. Between them, the vector walk and the directed cases cover every mode, every combination of the two enables, the forced float during load, and a reset that lands between clock edges and is followed by a shift on the very next edge.

// File: rtl/shreg_pkg.sv
package shreg_pkg;

  typedef enum logic [1:0] {
    MODE_HOLD = 2'b00,
    MODE_UP   = 2'b01,
    MODE_DOWN = 2'b10,
    MODE_LOAD = 2'b11
  } mode_e;

  typedef struct packed {
    logic load;
    logic shiftUp;
    logic shiftDown;
    logic drive;
  } strobe_t;

endpackage

// File: rtl/shreg_ctrl.sv
module shreg_ctrl
  import shreg_pkg::*;
(
  input  logic [1:0] modeSel,
  input  logic       oeAN,
  input  logic       oeBN,
  output strobe_t    strb
);

  mode_e mode;
  assign mode = mode_e'(modeSel);

  always_comb begin
    strb           = '0;
    strb.load      = (mode == MODE_LOAD);
    strb.shiftUp   = (mode == MODE_UP);
    strb.shiftDown = (mode == MODE_DOWN);
    // Drivers stay off while capturing, so the bus is free for the writer.
    strb.drive     = !oeAN && !oeBN && (mode != MODE_LOAD);
  end

endmodule

// File: rtl/shreg_datapath.sv
module shreg_datapath
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobe_t          strb,
  input  logic [WIDTH-1:0] busIn,
  input  logic             serInLow,
  input  logic             serInHigh,
  output logic [WIDTH-1:0] q
);

  localparam int MSB = WIDTH - 1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)               q <= '0;
    else if (strb.load)      q <= busIn;
    else if (strb.shiftUp)   q <= {q[MSB-1:0], serInLow};
    else if (strb.shiftDown) q <= {serInHigh, q[MSB:1]};
  end

  // R2: reset clears without waiting for an edge
  always @(negedge clk) begin
    if (!rstN) a_reset_clear_r2: assert (q == '0);
  end

  p_load_r1: assert property (@(posedge clk) disable iff (!rstN)
    strb.load |=> q == $past(busIn));

  p_shift_up_r4: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftUp |=> (q[0] == $past(serInLow)) && (q[MSB:1] == $past(q[MSB-1:0])));

  p_shift_down_r5: assert property (@(posedge clk) disable iff (!rstN)
    strb.shiftDown |=> (q[MSB] == $past(serInHigh)) && (q[MSB-1:0] == $past(q[MSB:1])));

  p_hold_r6: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.load || strb.shiftUp || strb.shiftDown) |=> $stable(q));

endmodule

// File: rtl/bidir_shift_reg.sv
module bidir_shift_reg
  import shreg_pkg::*;
#(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       modeSel,
  input  logic             serInLow,
  input  logic             serInHigh,
  input  logic             oeAN,
  input  logic             oeBN,
  inout  wire  [WIDTH-1:0] ioBus,
  output logic [WIDTH-1:0] dataOut,
  output logic             dataOutEn,
  output logic             serOutLow,
  output logic             serOutHigh
);

  strobe_t          strb;
  logic [WIDTH-1:0] regQ;

  shreg_ctrl ctrl_i (
    .modeSel (modeSel),
    .oeAN    (oeAN),
    .oeBN    (oeBN),
    .strb    (strb)
  );

  shreg_datapath #(.WIDTH(WIDTH)) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .busIn     (ioBus),
    .serInLow  (serInLow),
    .serInHigh (serInHigh),
    .q         (regQ)
  );

  assign dataOut    = regQ;
  assign dataOutEn  = strb.drive;
  assign ioBus      = strb.drive ? regQ : {WIDTH{1'bz}};
  assign serOutLow  = regQ[0];
  assign serOutHigh = regQ[WIDTH-1];

  p_drive_r7: assert property (@(posedge clk) disable iff (!rstN)
    (!oeAN && !oeBN && modeSel != 2'b11) |-> (dataOutEn && ioBus == dataOut));

  p_float_r8: assert property (@(posedge clk) disable iff (!rstN)
    (oeAN || oeBN) |-> !dataOutEn);

  p_load_hiz_r9: assert property (@(posedge clk) disable iff (!rstN)
    (modeSel == 2'b11) |-> !dataOutEn);

  p_taps_r10: assert property (@(posedge clk) disable iff (!rstN)
    (serOutLow == dataOut[0]) && (serOutHigh == dataOut[WIDTH-1]));

endmodule

// File: tb/bidir_shift_reg_tb_top.sv
module bidir_shift_reg_tb_top;

  localparam int WIDTH = 8;

  logic             clk = 1'b0;
  logic             rstN = 1'b0;
  logic [1:0]       modeSel = 2'b00;
  logic             serInLow = 1'b0, serInHigh = 1'b0;
  logic             oeAN = 1'b1, oeBN = 1'b1;
  logic             tbDrive = 1'b0;
  logic [WIDTH-1:0] tbVal = '0;
  wire  [WIDTH-1:0] ioBus;
  logic [WIDTH-1:0] dataOut;
  logic             dataOutEn, serOutLow, serOutHigh;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 1'b0;

  assign ioBus = tbDrive ? tbVal : {WIDTH{1'bz}};

  always #5 clk = ~clk;

  bidir_shift_reg #(.WIDTH(WIDTH)) dut_i (
    .clk(clk), .rstN(rstN), .modeSel(modeSel), .serInLow(serInLow),
    .serInHigh(serInHigh), .oeAN(oeAN), .oeBN(oeBN), .ioBus(ioBus),
    .dataOut(dataOut), .dataOutEn(dataOutEn), .serOutLow(serOutLow),
    .serOutHigh(serOutHigh)
  );

  // Fields: oeA, oeB, mode[1:0], serLow, serHigh, bus[7:0], expected[7:0]
  localparam logic [21:0] VEC [12] = '{
    {1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'hA5, 8'hA5},
    {1'b0, 1'b0, 2'b00, 1'b0, 1'b0, 8'h00, 8'hA5},
    {1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 8'h00, 8'h4B},
    {1'b0, 1'b1, 2'b01, 1'b0, 1'b0, 8'h11, 8'h96},
    {1'b1, 1'b0, 2'b10, 1'b0, 1'b1, 8'h22, 8'hCB},
    {1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 8'h00, 8'h65},
    {1'b0, 1'b0, 2'b11, 1'b0, 1'b0, 8'h3C, 8'h3C},
    {1'b1, 1'b1, 2'b00, 1'b1, 1'b1, 8'hC3, 8'h3C},
    {1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 8'h00, 8'h79},
    {1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 8'h00, 8'hBC},
    {1'b1, 1'b1, 2'b11, 1'b0, 1'b0, 8'hFF, 8'hFF},
    {1'b0, 1'b0, 2'b10, 1'b0, 1'b0, 8'h00, 8'h7F}
  };

  task automatic check(input string tag, input logic [WIDTH-1:0] act,
                       input logic [WIDTH-1:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic string modeTag(input logic [1:0] m);
    case (m)
      2'b00:   return "R6 hold";
      2'b01:   return "R4 shift up";
      2'b10:   return "R5 shift down";
      default: return "R1 load";
    endcase
  endfunction

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  endtask

  initial begin
    #(200000 * 10);
    failCount++;
    testCount++;
    $display("FAIL watchdog: actual expired expected done");
    finish_run();
  end

  initial begin
    logic expEn;
    // Reset state (R2)
    #12;
    check("R2 reset state", dataOut, 8'h00);
    check("R8 reset enable", {7'b0, dataOutEn}, 8'h00);
    @(negedge clk);
    rstN = 1'b1;

    foreach (VEC[i]) begin
      oeAN      = VEC[i][21];
      oeBN      = VEC[i][20];
      modeSel   = VEC[i][19:18];
      serInLow  = VEC[i][17];
      serInHigh = VEC[i][16];
      tbVal     = VEC[i][15:8];
      expEn     = !VEC[i][21] && !VEC[i][20] && (VEC[i][19:18] != 2'b11);
      tbDrive   = !expEn;
      @(posedge clk);
      @(negedge clk);
      check(modeTag(VEC[i][19:18]), dataOut, VEC[i][7:0]);
      check("R10 serial taps", {6'b0, serOutHigh, serOutLow},
            {6'b0, VEC[i][7], VEC[i][0]});
      if (VEC[i][19:18] == 2'b11)
        check("R9 load forces float", {7'b0, dataOutEn}, 8'h00);
      else if (expEn)
        check("R7 bus driven", {7'b0, dataOutEn}, 8'h01);
      else
        check("R8 bus floats", {7'b0, dataOutEn}, 8'h00);
      if (expEn)
        check("R7 bus value", ioBus, VEC[i][7:0]);
      else
        check("R8 bus owned by bench", ioBus, VEC[i][15:8]);
    end

    // Load a value, then assert reset between edges (R2)
    oeAN = 1'b1; oeBN = 1'b1; tbDrive = 1'b1;
    modeSel = 2'b11; tbVal = 8'h5A;
    @(posedge clk);
    @(negedge clk);
    check("R1 load before reset", dataOut, 8'h5A);
    #2 rstN = 1'b0;
    #1;
    check("R2 async clear", dataOut, 8'h00);
    check("R10 taps cleared", {6'b0, serOutHigh, serOutLow}, 8'h00);

    // First edge after release shifts at once (R3)
    @(negedge clk);
    modeSel = 2'b01; serInLow = 1'b1; rstN = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check("R3 first edge shift", dataOut, 8'h01);

    // Fill with ones, then walk one out the top tap with enables off (R10, R4)
    for (int k = 0; k < 7; k++) @(posedge clk);
    @(negedge clk);
    check("R4 fill ones", dataOut, 8'hFF);
    modeSel = 2'b10; serInHigh = 1'b0;
    @(posedge clk);
    @(negedge clk);
    check("R5 zero in at top", dataOut, 8'h7F);
    check("R10 top tap low", {7'b0, serOutHigh}, 8'h00);

    // Load mode with both enables low still floats the drivers (R9)
    oeAN = 1'b0; oeBN = 1'b0; modeSel = 2'b11; tbVal = 8'h81;
    #1;
    check("R9 enable off in load", {7'b0, dataOutEn}, 8'h00);
    @(posedge clk);
    @(negedge clk);
    check("R1 capture with enables low", dataOut, 8'h81);

    finish_run();
  end

endmodule